// File: doc/BRIEF.md
# Peripheral Clock-Gate Disable Unit

This block sits in front of the register banks of a group of small peripherals. Each peripheral gets one disable bit. A disabled peripheral loses its clock enable. Its registers then behave as if their power were gone: bus writes do nothing, and bus reads return a fixed poison byte with an invalid flag raised. Software sets and clears the disable bits through two 8-bit control registers that share the bus with the peripheral registers.

When software clears a disable bit that was set, the peripheral comes back with fresh reset defaults and not with its old contents. The reload takes one cycle, in the cycle right after the clearing write. During that cycle the bank is still treated as unpowered, so a write landing in it is dropped and a read returns poison. The bus is a single-cycle write port and a read port with one cycle of latency. Both share one address.

Top module: `pcg_gate_top`

## Requirements
- R1: Reset (active-low `rst_n`) clears every disable bit, raises every `mod_clk_en` bit, loads every peripheral register with its default, and sets `bus_rdata` to 0 with `bus_rinvalid` low.
- R2: An address with MSB 0 selects the control space, and address bit 0 picks the bank. Bank 0 holds the disable bits of modules 0–7 and bank 1 those of modules 8–15, with bit i of a bank belonging to module 8·bank+i. Writes update the bits of existing modules. Reads return those bits and 0 for modules that are not built.
- R3: `mod_clk_en[m]` is the inverse of module m's disable bit and changes at the clock edge that captures the control write.
- R4: An address with MSB 1 selects peripheral space, with module index in bits [REG_W+3:REG_W] and register index in bits [REG_W-1:0]. A write to an enabled module updates the register at that edge. A read returns the stored value with `bus_rinvalid` low on the edge after it is issued.
- R5: A write to a disabled module changes no register of any module.
- R6: A read of a disabled module returns 8'hDE with `bus_rinvalid` high.
- R7: Writing 0 to a disable bit that was 1 reloads that module's registers with their defaults on the next edge. Writing 0 to a bit that is already 0 reloads nothing.
- R8: In the cycle after a clearing write, a write to the reloading module is dropped and a read of it returns 8'hDE with `bus_rinvalid` high.
- R9: A peripheral address whose module index is NUM_MODS or above reads as 8'hDE with `bus_rinvalid` high. Writes to it change nothing.
- R10: A read and a write to the same address in the same cycle return the contents from before the write.
- R11: The default of register r in module m is {m[3:0], r[2:0], 1'b1}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Address (control or peripheral space) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, one cycle after the read strobe |
| bus_rinvalid | output | 1 | Read data is poison |
| mod_clk_en | output | NUM_MODS | Clock enable per module |

## Verification
Writes and control changes take effect at the edge that captures them, so `mod_clk_en` and register contents are due one edge after the strobe. Read data is registered and is due on the edge after the read is issued. The default reload lands one edge after the clearing write. The bench drives every input on the falling edge and checks results on the next falling edge. That is half a period after the edge that produced the result. A read placed in the cycle directly after a clearing write is how the bench looks into the one-cycle reload window.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
  localparam int DATA_W    = 8;
  localparam int BANK_W    = 8;
  localparam int MAX_MODS  = 2 * BANK_W;
  localparam int MOD_W     = $clog2(MAX_MODS);
  localparam logic [DATA_W-1:0] POISON = 8'hDE;

  // Default contents of register r of module m.
  function automatic logic [DATA_W-1:0] reset_value(input int unsigned m, input int unsigned r);
    logic [3:0] mf;
    logic [2:0] rf;
    mf = 4'(m);
    rf = 3'(r);
    return {mf, rf, 1'b1};
  endfunction
endpackage

// File: rtl/pcg_ctrl.sv
module pcg_ctrl #(
  parameter int NUM_MODS = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ctrl_wr,
  input  logic                          bank_sel,
  input  logic [pcg_pkg::BANK_W-1:0]    wdata,
  output logic [NUM_MODS-1:0]           dis,
  output logic [NUM_MODS-1:0]           reload_pend,
  output logic [pcg_pkg::MAX_MODS-1:0]  ctrl_view
);
  localparam int BW = pcg_pkg::BANK_W;

  logic [NUM_MODS-1:0] next_dis;
  logic [NUM_MODS-1:0] clear_now;

  for (genvar m = 0; m < NUM_MODS; m++) begin : g_bit
    localparam int BANK = m / BW;
    localparam int BIT  = m % BW;
    assign next_dis[m]  = (ctrl_wr && (bank_sel == 1'(BANK))) ? wdata[BIT] : dis[m];
    assign clear_now[m] = dis[m] & ~next_dis[m];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dis         <= '0;
      reload_pend <= '0;
    end else begin
      dis         <= next_dis;
      reload_pend <= clear_now;
    end
  end

  always_comb begin
    ctrl_view = '0;
    ctrl_view[NUM_MODS-1:0] = dis;
  end
endmodule

// File: rtl/pcg_regbank.sv
module pcg_regbank #(
  parameter int MOD_ID       = 0,
  parameter int REGS_PER_MOD = 4,
  localparam int REG_W       = $clog2(REGS_PER_MOD),
  localparam int DW          = pcg_pkg::DATA_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_hit,
  input  logic [REG_W-1:0]           reg_idx,
  input  logic [DW-1:0]              wdata,
  input  logic                       disabled,
  input  logic                       reload,
  output logic [REGS_PER_MOD*DW-1:0] regs
);
  logic write_ok;
  assign write_ok = wr_hit & ~disabled & ~reload;

  for (genvar r = 0; r < REGS_PER_MOD; r++) begin : g_reg
    localparam logic [DW-1:0] RV = pcg_pkg::reset_value(MOD_ID, r);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[r*DW +: DW] <= RV;
      else if (reload)
        regs[r*DW +: DW] <= RV;
      else if (write_ok && (reg_idx == REG_W'(r)))
        regs[r*DW +: DW] <= wdata;
    end
  end
endmodule

// File: rtl/pcg_rdmux.sv
module pcg_rdmux #(
  parameter int NUM_MODS     = 12,
  parameter int REGS_PER_MOD = 4,
  localparam int REG_W       = $clog2(REGS_PER_MOD),
  localparam int MW          = pcg_pkg::MOD_W,
  localparam int MM          = pcg_pkg::MAX_MODS,
  localparam int DW          = pcg_pkg::DATA_W
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                rd_en,
  input  logic                                is_periph,
  input  logic                                present,
  input  logic                                bank_sel,
  input  logic [MW-1:0]                       mod_idx,
  input  logic [REG_W-1:0]                    reg_idx,
  input  logic [MM-1:0]                       ctrl_view,
  input  logic [MM-1:0]                       dead_pad,
  input  logic [NUM_MODS*REGS_PER_MOD*DW-1:0] reg_flat,
  output logic [DW-1:0]                       rdata,
  output logic                                rinvalid
);
  logic [DW-1:0] word;

  always_comb begin
    word = '0;
    for (int m = 0; m < NUM_MODS; m++)
      for (int r = 0; r < REGS_PER_MOD; r++)
        if (mod_idx == MW'(m) && reg_idx == REG_W'(r))
          word = reg_flat[(m*REGS_PER_MOD + r)*DW +: DW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata    <= '0;
      rinvalid <= 1'b0;
    end else if (rd_en) begin
      if (!is_periph) begin
        rdata    <= bank_sel ? ctrl_view[MM-1 -: DW] : ctrl_view[DW-1:0];
        rinvalid <= 1'b0;
      end else if (!present || dead_pad[mod_idx]) begin
        rdata    <= pcg_pkg::POISON;
        rinvalid <= 1'b1;
      end else begin
        rdata    <= word;
        rinvalid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pcg_gate_top.sv
module pcg_gate_top #(
  parameter int NUM_MODS     = 12,
  parameter int REGS_PER_MOD = 4,
  localparam int ADDR_W      = 1 + pcg_pkg::MOD_W + $clog2(REGS_PER_MOD)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_wr,
  input  logic                        bus_rd,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [pcg_pkg::DATA_W-1:0]  bus_wdata,
  output logic [pcg_pkg::DATA_W-1:0]  bus_rdata,
  output logic                        bus_rinvalid,
  output logic [NUM_MODS-1:0]         mod_clk_en
);
  localparam int REG_W = $clog2(REGS_PER_MOD);
  localparam int MW    = pcg_pkg::MOD_W;
  localparam int MM    = pcg_pkg::MAX_MODS;
  localparam int DW    = pcg_pkg::DATA_W;

  // Address decode
  logic             is_periph;
  logic [MW-1:0]    mod_idx;
  logic [REG_W-1:0] reg_idx;
  logic             present;
  logic             ctrl_wr;

  assign is_periph = bus_addr[ADDR_W-1];
  assign mod_idx   = bus_addr[REG_W +: MW];
  assign reg_idx   = bus_addr[REG_W-1:0];
  assign present   = {1'b0, mod_idx} < (MW+1)'(NUM_MODS);
  assign ctrl_wr   = bus_wr & ~is_periph;

  logic [NUM_MODS-1:0]                 dis;
  logic [NUM_MODS-1:0]                 reload_pend;
  logic [MM-1:0]                       ctrl_view;
  logic [MM-1:0]                       dead_pad;
  logic [NUM_MODS*REGS_PER_MOD*DW-1:0] reg_flat;
  logic                                write_blocked;

  pcg_ctrl #(.NUM_MODS(NUM_MODS)) ctrl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_wr     (ctrl_wr),
    .bank_sel    (bus_addr[0]),
    .wdata       (bus_wdata),
    .dis         (dis),
    .reload_pend (reload_pend),
    .ctrl_view   (ctrl_view)
  );

  // A module counts as unpowered while disabled and during its reload cycle.
  always_comb begin
    dead_pad = '0;
    dead_pad[NUM_MODS-1:0] = dis | reload_pend;
  end

  assign write_blocked = bus_wr & is_periph & (~present | dead_pad[mod_idx]);
  assign mod_clk_en    = ~dis;

  for (genvar m = 0; m < NUM_MODS; m++) begin : g_mod
    pcg_regbank #(.MOD_ID(m), .REGS_PER_MOD(REGS_PER_MOD)) bank_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_hit   (bus_wr & is_periph & (mod_idx == MW'(m))),
      .reg_idx  (reg_idx),
      .wdata    (bus_wdata),
      .disabled (dis[m]),
      .reload   (reload_pend[m]),
      .regs     (reg_flat[m*REGS_PER_MOD*DW +: REGS_PER_MOD*DW])
    );
  end

  pcg_rdmux #(.NUM_MODS(NUM_MODS), .REGS_PER_MOD(REGS_PER_MOD)) rdmux_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (bus_rd),
    .is_periph (is_periph),
    .present   (present),
    .bank_sel  (bus_addr[0]),
    .mod_idx   (mod_idx),
    .reg_idx   (reg_idx),
    .ctrl_view (ctrl_view),
    .dead_pad  (dead_pad),
    .reg_flat  (reg_flat),
    .rdata     (bus_rdata),
    .rinvalid  (bus_rinvalid)
  );
endmodule

// File: rtl/pcg_gate_chk.sv
module pcg_gate_chk #(
  parameter int NUM_MODS     = 12,
  parameter int REGS_PER_MOD = 4,
  parameter int ADDR_W       = 7
) (
  input logic                                         clk,
  input logic                                         rst_n,
  input logic                                         bus_wr,
  input logic                                         bus_rd,
  input logic [ADDR_W-1:0]                            bus_addr,
  input logic [pcg_pkg::DATA_W-1:0]                   bus_wdata,
  input logic [pcg_pkg::DATA_W-1:0]                   bus_rdata,
  input logic                                         bus_rinvalid,
  input logic [NUM_MODS-1:0]                          mod_clk_en,
  input logic [NUM_MODS-1:0]                          reload_pend,
  input logic [NUM_MODS*REGS_PER_MOD*pcg_pkg::DATA_W-1:0] reg_flat
);
  localparam int DW    = pcg_pkg::DATA_W;
  localparam int REG_W = $clog2(REGS_PER_MOD);
  localparam int MW    = pcg_pkg::MOD_W;
  localparam int SL    = REGS_PER_MOD * DW;
  localparam logic [ADDR_W-1:0] A_M0R1 = ADDR_W'((1 << (ADDR_W-1)) | 1);

  logic          periph;
  logic [MW-1:0] mod;
  logic          present;
  logic [pcg_pkg::MAX_MODS-1:0] en_pad;
  logic          targets_m1;

  assign periph     = bus_addr[ADDR_W-1];
  assign mod        = bus_addr[REG_W +: MW];
  assign present    = {1'b0, mod} < (MW+1)'(NUM_MODS);
  assign targets_m1 = periph && (mod == MW'(1));
  always_comb begin
    en_pad = '0;
    en_pad[NUM_MODS-1:0] = mod_clk_en;
  end

  a_r3_disable_drops_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !periph && !bus_addr[0] && bus_wdata[0]) |=> !mod_clk_en[0]);

  a_r4_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_M0R1 && mod_clk_en[0] && !reload_pend[0])
      |=> reg_flat[2*DW-1:DW] == $past(bus_wdata));

  a_r5_disabled_bank_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_clk_en[1] |=> $stable(reg_flat[SL +: SL]));

  a_r6_poison_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && periph && present && !en_pad[mod])
      |=> (bus_rinvalid && bus_rdata == pcg_pkg::POISON));

  a_r7_reload_defaults: assert property (@(posedge clk) disable iff (!rst_n)
    reload_pend[1] |=> reg_flat[SL +: DW] == pcg_pkg::reset_value(1, 0));

  a_r8_reload_beats_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_pend[1] && bus_wr && targets_m1)
      |=> reg_flat[SL + DW*(REGS_PER_MOD-1) +: DW] == pcg_pkg::reset_value(1, REGS_PER_MOD-1));

  a_r9_absent_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && periph && !present) |=> bus_rinvalid);
endmodule

bind pcg_gate_top pcg_gate_chk #(
  .NUM_MODS(NUM_MODS), .REGS_PER_MOD(REGS_PER_MOD), .ADDR_W(ADDR_W)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_wr       (bus_wr),
  .bus_rd       (bus_rd),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .bus_rdata    (bus_rdata),
  .bus_rinvalid (bus_rinvalid),
  .mod_clk_en   (mod_clk_en),
  .reload_pend  (reload_pend),
  .reg_flat     (reg_flat)
);

// File: tb/pcg_gate_top_tb.sv
module pcg_gate_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NM = 12;
  localparam int NR = 4;
  localparam int AW = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0]    bus_wdata = '0;
  logic [7:0]    bus_rdata;
  logic          bus_rinvalid;
  logic [NM-1:0] mod_clk_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcg_gate_top #(.NUM_MODS(NM), .REGS_PER_MOD(NR)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rinvalid(bus_rinvalid), .mod_clk_en(mod_clk_en)
  );

  // Defaults restated from R11: module in the high nibble, register doubled, low bit set.
  function automatic logic [7:0] dflt(input int m, input int r);
    return 8'(m * 16 + r * 2 + 1);
  endfunction

  function automatic logic [AW-1:0] pa(input int m, input int r);
    return AW'(64 + m * 4 + r);
  endfunction

  task automatic cyc(input bit w, input bit r, input logic [AW-1:0] a, input logic [7:0] d);
    bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic chk_rd(input string req, input logic [7:0] exp_d, input bit exp_i);
    checks++;
    if (bus_rdata !== exp_d || bus_rinvalid !== exp_i) begin
      errors++;
      $display("FAIL %s: rdata=%h inv=%b expected rdata=%h inv=%b", req, bus_rdata, bus_rinvalid, exp_d, exp_i);
    end
  endtask

  task automatic chk_en(input string req, input logic [NM-1:0] exp_e);
    checks++;
    if (mod_clk_en !== exp_e) begin
      errors++;
      $display("FAIL %s: mod_clk_en=%h expected %h", req, mod_clk_en, exp_e);
    end
  endtask

  // Vector: {op(1=read,0=write), addr, wdata, exp_data, exp_inv, req}
  localparam logic [28:0] VEC [16] = '{
    {1'b1, 7'h40, 8'h00, 8'h01, 1'b0, 4'd11},  // R11 default m0 r0
    {1'b1, 7'h6F, 8'h00, 8'hB7, 1'b0, 4'd11},  // R11 default m11 r3
    {1'b0, 7'h41, 8'h3C, 8'h00, 1'b0, 4'd4 },
    {1'b1, 7'h41, 8'h00, 8'h3C, 1'b0, 4'd4 },  // R4 write then read
    {1'b0, 7'h00, 8'h02, 8'h00, 1'b0, 4'd2 },  // disable m1
    {1'b1, 7'h00, 8'h00, 8'h02, 1'b0, 4'd2 },  // R2 read back
    {1'b1, 7'h44, 8'h00, 8'hDE, 1'b1, 4'd6 },  // R6 poison
    {1'b0, 7'h44, 8'h77, 8'h00, 1'b0, 4'd5 },  // blocked write
    {1'b1, 7'h41, 8'h00, 8'h3C, 1'b0, 4'd5 },  // R5 neighbour untouched
    {1'b0, 7'h01, 8'hFF, 8'h00, 1'b0, 4'd2 },
    {1'b1, 7'h01, 8'h00, 8'h0F, 1'b0, 4'd2 },  // R2 absent bits read 0
    {1'b1, 7'h60, 8'h00, 8'hDE, 1'b1, 4'd6 },
    {1'b0, 7'h01, 8'h00, 8'h00, 1'b0, 4'd7 },  // clear m8..m11
    {1'b1, 7'h60, 8'h00, 8'hDE, 1'b1, 4'd8 },  // R8 reload cycle poison
    {1'b1, 7'h60, 8'h00, 8'h81, 1'b0, 4'd7 },  // R7 default after reload
    {1'b1, 7'h70, 8'h00, 8'hDE, 1'b1, 4'd9 }   // R9 absent module
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    repeat (2) @(negedge clk);
    // R1 reset state
    chk_rd("R1", 8'h00, 1'b0);
    chk_en("R1", {NM{1'b1}});
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 16; i++) begin
      cyc(~VEC[i][28], VEC[i][28], VEC[i][27:21], VEC[i][20:13]);
      if (VEC[i][28]) chk_rd($sformatf("R%0d", VEC[i][3:0]), VEC[i][12:5], VEC[i][4]);
    end

    // R3 enable reflects disable bits (m1 still off)
    chk_en("R3", 12'hFFD);

    // R8 write in reload cycle is dropped
    cyc(1, 0, 7'h00, 8'h00);
    cyc(1, 0, pa(1, 0), 8'h55);
    cyc(0, 1, pa(1, 0), 8'h00);
    chk_rd("R8", dflt(1, 0), 1'b0);
    chk_en("R3", {NM{1'b1}});

    // R7 clearing an already-clear bit keeps contents
    cyc(1, 0, pa(1, 0), 8'h99);
    cyc(1, 0, 7'h00, 8'h00);
    cyc(0, 1, pa(1, 0), 8'h00);
    chk_rd("R7", 8'h99, 1'b0);

    // R7 disable then enable restores default
    cyc(1, 0, 7'h00, 8'h02);
    cyc(1, 0, 7'h00, 8'h00);
    cyc(0, 0, 7'h00, 8'h00);
    cyc(0, 1, pa(1, 0), 8'h00);
    chk_rd("R7", dflt(1, 0), 1'b0);

    // R10 simultaneous read and write
    cyc(1, 1, pa(0, 1), 8'h5A);
    chk_rd("R10", 8'h3C, 1'b0);
    cyc(0, 1, pa(0, 1), 8'h00);
    chk_rd("R10", 8'h5A, 1'b0);

    // R9 write to absent module changes nothing
    cyc(1, 0, pa(12, 0), 8'hAA);
    cyc(0, 1, pa(11, 0), 8'h00);
    chk_rd("R9", dflt(11, 0), 1'b0);
    cyc(0, 1, pa(0, 0), 8'h00);
    chk_rd("R9", dflt(0, 0), 1'b0);

    // R1 reset mid-run restores defaults and clears disable bits
    cyc(1, 0, 7'h00, 8'h01);
    rst_n = 1'b0;
    @(negedge clk);
    chk_en("R1", {NM{1'b1}});
    rst_n = 1'b1;
    @(negedge clk);
    cyc(0, 1, pa(0, 1), 8'h00);
    chk_rd("R1", dflt(0, 1), 1'b0);
    cyc(0, 1, 7'h00, 8'h00);
    chk_rd("R1", 8'h00, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule